// File: doc/BRIEF.md
# Byte Lane Alignment Controller

This block sits between a byte or word transfer request and the bus sequencer of a processor with a 16-bit data bus. Its memory and port space is split into two banks. The even bank holds even-addressed bytes and connects to data lines 7:0. The odd bank holds odd-addressed bytes and connects to data lines 15:8. Address bits above bit 0 select the same location in both banks at once. The block decides whether a transfer needs one bus cycle or two. It drives address bit 0 and an active-low upper-bank enable, and it puts each write byte on the correct lane. On a read it moves the returned bytes into a right-justified result.

A word at an odd address cannot be moved in one cycle. The block splits it into two cycles. The first cycle moves the low-order byte on the upper lane at the original address. The second cycle moves the high-order byte on the lower lane at the incremented address. The bus sequencer owns the timing of each cycle. It marks the end of each cycle with `cycDone`, and it supplies the common active-low read and write commands. The block combines those commands with address bit 0 and the upper-bank enable to form separate read and write strobes for each bank. The same rules apply to memory and to I/O ports.

Top module: `byte_lane_ctrl`

## Requirements
- R1: After reset, `reqReady` is 1, `cycValid` is 0, `done` is 0 and all four bank strobes are 1.
- R2: A byte transfer at an even address takes one cycle with `busAddr[0]`=0 and `bankHiEn_n`=1. Write data is on lines 7:0. Read data is taken from lines 7:0 into `rdata[7:0]`.
- R3: A byte transfer at an odd address takes one cycle with `busAddr[0]`=1 and `bankHiEn_n`=0. Write data is on lines 15:8. Read data is taken from lines 15:8 and returned in `rdata[7:0]`.
- R4: A word at an even address takes one cycle with `busAddr[0]`=0 and `bankHiEn_n`=0. The low-order byte is on lines 7:0 and the high-order byte is on lines 15:8.
- R5: A word at an odd address takes two cycles. The first cycle is at the request address with `bankHiEn_n`=0 and the low-order byte on lines 15:8. The second cycle is at the request address plus one, with bit 0 equal to 0, `bankHiEn_n`=1 and the high-order byte on lines 7:0. On a read, both halves are merged into `rdata` before `done` is raised.
- R6: During a bus cycle, the lower-bank strobes equal the command OR `busAddr[0]`, and the upper-bank strobes equal the command OR `bankHiEn_n`. The read strobes come from `rdCmd_n` and the write strobes come from `wrCmd_n`.
- R7: When no bus cycle is in progress, all four bank strobes stay at 1 whatever the commands are.
- R8: `reqReady` is 0 from acceptance until the final cycle of the transfer completes. A request presented in that time has no effect on the bus address, enable or lanes.
- R9: `done` is a one-clock pulse in the clock after the final `cycDone`. `rdata` holds the read result in that clock, and `reqReady` is 1 again in that same clock.
- R10: The increment for the second cycle of a split word wraps at the top of the address space. A word at the highest odd address continues at address 0.
- R11: On writes, the lane that carries no data in a cycle is driven with zeros. On byte reads, `rdata[15:8]` is 0.
- R12: The bus address, upper-bank enable and write lanes stay constant while a cycle waits for `cycDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word, 0 = byte |
| reqAddr | input | ADDR_W | Byte address of the transfer |
| reqWdata | input | 2*LANE_W | Write data, right-justified |
| reqReady | output | 1 | Block can accept a request |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 2*LANE_W | Read result, right-justified |
| cycValid | output | 1 | A bus cycle is requested |
| busWrite | output | 1 | Direction of the current cycle |
| busAddr | output | ADDR_W | Cycle address, bit 0 is A0 |
| bankHiEn_n | output | 1 | Upper-bank enable, active low |
| busWdata | output | 2*LANE_W | Lane-steered write data |
| busRdata | input | 2*LANE_W | Data returned by the banks |
| cycDone | input | 1 | Current bus cycle has completed |
| rdCmd_n | input | 1 | Common read command, active low |
| wrCmd_n | input | 1 | Common write command, active low |
| rdLo_n | output | 1 | Lower-bank read strobe |
| rdHi_n | output | 1 | Upper-bank read strobe |
| wrLo_n | output | 1 | Lower-bank write strobe |
| wrHi_n | output | 1 | Upper-bank write strobe |

## Verification
The `done` pulse of one transfer and the acceptance of the next can fall in the same clock, because `reqReady` returns together with `done`. The bench holds `reqValid` high throughout a split odd-word write. It changes the request fields while the block is busy and checks that both bus cycles still show the original address and lanes. In the clock where `done` appears, it checks that `reqReady` is high. It then checks that the held request starts its own cycle on the next clock with the new address and lane choice.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } blcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic active;   // a bus cycle is in progress
    logic second;   // second half of a split word
    logic capture;  // current cycle completes this clock
  } blcCtrl_t;
endpackage

// File: rtl/blc_ctrl.sv
module blc_ctrl
  import blc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     cycDone,
  input  logic     needTwo,
  output blcCtrl_t ctrl,
  output logic     reqReady,
  output logic     cycValid,
  output logic     done
);
  blcState_t state, stateNext;
  logic      lastCycle;

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && reqValid;
    ctrl.active  = (state != ST_IDLE);
    ctrl.second  = (state == ST_SECOND);
    ctrl.capture = ctrl.active && cycDone;
    lastCycle    = ctrl.second || !needTwo;
    stateNext    = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_FIRST;
      ST_FIRST:  if (cycDone)  stateNext = needTwo ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (cycDone)  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctrl.capture && lastCycle;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign cycValid = ctrl.active;

  // done only follows a completed bus cycle
  assert_done_after_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cycDone));
  // second half only entered when the datapath reported a split
  assert_split_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.second && !$past(ctrl.second)) |-> $past(needTwo));
  // a cycle never starts without a request
  assert_start_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycValid) |-> $past(reqValid));
endmodule

// File: rtl/blc_dpath.sv
module blc_dpath
  import blc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  blcCtrl_t            ctrl,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic [2*LANE_W-1:0] busRdata,
  input  logic                rdCmd_n,
  input  logic                wrCmd_n,
  output logic                needTwo,
  output logic                busWrite,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                bankHiEn_n,
  output logic [2*LANE_W-1:0] busWdata,
  output logic [2*LANE_W-1:0] rdata,
  output logic                rdLo_n,
  output logic                rdHi_n,
  output logic                wrLo_n,
  output logic                wrHi_n
);
  localparam int BUS_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] LANE_ZERO = '0;
  localparam logic [ADDR_W-1:0] ADDR_ONE  = 1;

  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wdQ, rdQ;
  logic              isWord, isWrite, isOdd, a0, idle;
  logic [LANE_W-1:0] wdLow, wdHigh, rdLane0, rdLane1;

  assign wdLow   = wdQ[LANE_W-1:0];
  assign wdHigh  = wdQ[BUS_W-1:LANE_W];
  assign rdLane0 = busRdata[LANE_W-1:0];
  assign rdLane1 = busRdata[BUS_W-1:LANE_W];
  assign isOdd   = addrQ[0];
  assign needTwo = isWord && isOdd;
  assign busWrite = isWrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ   <= '0;
      wdQ     <= '0;
      isWord  <= 1'b0;
      isWrite <= 1'b0;
    end else if (ctrl.load) begin
      addrQ   <= reqAddr;
      wdQ     <= reqWdata;
      isWord  <= reqWord;
      isWrite <= reqWrite;
    end
  end

  // address, bank enable and write lane steering
  always_comb begin
    busAddr    = addrQ;
    bankHiEn_n = 1'b1;
    busWdata   = '0;
    if (ctrl.active) begin
      if (ctrl.second) begin
        busAddr    = addrQ + ADDR_ONE;
        bankHiEn_n = 1'b1;
        busWdata   = {LANE_ZERO, wdHigh};
      end else begin
        bankHiEn_n = !(isWord || isOdd);
        if (isOdd)       busWdata = {wdLow, LANE_ZERO};
        else if (isWord) busWdata = wdQ;
        else             busWdata = {LANE_ZERO, wdLow};
      end
    end
  end

  // read reassembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdQ <= '0;
    end else if (ctrl.capture && !isWrite) begin
      if (ctrl.second)      rdQ[BUS_W-1:LANE_W] <= rdLane0;
      else if (isOdd)       rdQ <= {LANE_ZERO, rdLane1};
      else if (isWord)      rdQ <= busRdata;
      else                  rdQ <= {LANE_ZERO, rdLane0};
    end
  end
  assign rdata = rdQ;

  // per-bank strobes
  assign a0     = busAddr[0];
  assign idle   = !ctrl.active;
  assign rdLo_n = rdCmd_n | a0 | idle;
  assign rdHi_n = rdCmd_n | bankHiEn_n | idle;
  assign wrLo_n = wrCmd_n | a0 | idle;
  assign wrHi_n = wrCmd_n | bankHiEn_n | idle;

  assert_bank_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.active |-> !(a0 && bankHiEn_n));
  assert_second_low_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.active && ctrl.second) |-> (!a0 && bankHiEn_n));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.active |-> (rdLo_n && rdHi_n && wrLo_n && wrHi_n));
  assert_hold_during_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.active && $past(ctrl.active) && (ctrl.second == $past(ctrl.second)))
      |-> ($stable(busAddr) && $stable(bankHiEn_n) && $stable(busWdata)));
endmodule

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
  import blc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  output logic                reqReady,
  output logic                done,
  output logic [2*LANE_W-1:0] rdata,
  output logic                cycValid,
  output logic                busWrite,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                bankHiEn_n,
  output logic [2*LANE_W-1:0] busWdata,
  input  logic [2*LANE_W-1:0] busRdata,
  input  logic                cycDone,
  input  logic                rdCmd_n,
  input  logic                wrCmd_n,
  output logic                rdLo_n,
  output logic                rdHi_n,
  output logic                wrLo_n,
  output logic                wrHi_n
);
  blcCtrl_t ctrl;
  logic     needTwo;

  blc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .cycDone(cycDone),
    .needTwo(needTwo), .ctrl(ctrl), .reqReady(reqReady),
    .cycValid(cycValid), .done(done)
  );

  blc_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busRdata(busRdata), .rdCmd_n(rdCmd_n), .wrCmd_n(wrCmd_n),
    .needTwo(needTwo), .busWrite(busWrite), .busAddr(busAddr),
    .bankHiEn_n(bankHiEn_n), .busWdata(busWdata), .rdata(rdata),
    .rdLo_n(rdLo_n), .rdHi_n(rdHi_n), .wrLo_n(wrLo_n), .wrHi_n(wrHi_n)
  );
endmodule

// File: tb/byte_lane_ctrl_tb.sv
module byte_lane_ctrl_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0]   reqWdata = '0, busRdata = '0;
  logic          cycDone = 1'b0, rdCmd_n = 1'b1, wrCmd_n = 1'b1;
  logic          reqReady, done, cycValid, busWrite, bankHiEn_n;
  logic [15:0]   rdata, busWdata;
  logic [AW-1:0] busAddr;
  logic          rdLo_n, rdHi_n, wrLo_n, wrHi_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  byte_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .done(done), .rdata(rdata), .cycValid(cycValid),
    .busWrite(busWrite), .busAddr(busAddr), .bankHiEn_n(bankHiEn_n),
    .busWdata(busWdata), .busRdata(busRdata), .cycDone(cycDone),
    .rdCmd_n(rdCmd_n), .wrCmd_n(wrCmd_n), .rdLo_n(rdLo_n), .rdHi_n(rdHi_n),
    .wrLo_n(wrLo_n), .wrHi_n(wrHi_n)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'hA5 ^ a[19:12];
  endfunction

  function automatic logic [15:0] bankWord(input logic [AW-1:0] a);
    logic [AW-1:0] ev;
    ev = {a[AW-1:1], 1'b0};
    return {memByte(ev | 1), memByte(ev)};
  endfunction

  // one bus cycle as seen by the sequencer and the banks; entered at a negedge
  task automatic serveCycle(input string rq, input logic [AW-1:0] expA, input logic expHi,
                            input logic [15:0] expW, input logic wr, input int waits);
    chk({rq, " cycValid"}, cycValid, 1);
    chk({rq, " busAddr"}, busAddr, expA);
    chk({rq, " bankHiEn_n"}, bankHiEn_n, expHi);
    chk({rq, " busWrite"}, busWrite, wr);
    if (wr) chk({rq, " R11 lanes"}, busWdata, expW);
    if (wr) wrCmd_n = 1'b0; else rdCmd_n = 1'b0;
    #1;
    // R6: lower = cmd | A0, upper = cmd | enable
    chk("R6 rdLo_n", rdLo_n, wr ? 1'b1 : expA[0]);
    chk("R6 rdHi_n", rdHi_n, wr ? 1'b1 : expHi);
    chk("R6 wrLo_n", wrLo_n, wr ? expA[0] : 1'b1);
    chk("R6 wrHi_n", wrHi_n, wr ? expHi : 1'b1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R12 addr held", busAddr, expA);
      chk("R12 enable held", bankHiEn_n, expHi);
      if (wr) chk("R12 lanes held", busWdata, expW);
      chk("R8 busy", reqReady, 0);
    end
    busRdata = bankWord(expA);
    cycDone  = 1'b1;
    @(negedge clk);
    cycDone  = 1'b0;
    rdCmd_n  = 1'b1;
    wrCmd_n  = 1'b1;
    busRdata = 16'h0;
  endtask

  task automatic startReq(input logic wr, input logic wd, input logic [AW-1:0] a,
                          input logic [15:0] d);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic xfer(input string rq, input logic wr, input logic wd,
                      input logic [AW-1:0] a, input logic [15:0] d, input int waits);
    logic [15:0] expR;
    chk({rq, " ready before"}, reqReady, 1);
    startReq(wr, wd, a, d);
    if (wd && a[0]) begin
      serveCycle({rq, " R5 first"}, a, 1'b0, {d[7:0], 8'h00}, wr, waits);
      chk("R8 ready between halves", reqReady, 0);
      chk("R9 no early done", done, 0);
      serveCycle({rq, " R5 second"}, a + 1'b1, 1'b1, {8'h00, d[15:8]}, wr, waits);
      expR = {memByte(a + 1'b1), memByte(a)};
    end else if (wd) begin
      serveCycle({rq, " R4"}, a, 1'b0, d, wr, waits);
      expR = {memByte(a + 1'b1), memByte(a)};
    end else if (a[0]) begin
      serveCycle({rq, " R3"}, a, 1'b0, {d[7:0], 8'h00}, wr, waits);
      expR = {8'h00, memByte(a)};
    end else begin
      serveCycle({rq, " R2"}, a, 1'b1, {8'h00, d[7:0]}, wr, waits);
      expR = {8'h00, memByte(a)};
    end
    chk({rq, " R9 done"}, done, 1);
    chk({rq, " R9 ready back"}, reqReady, 1);
    if (!wr) chk({rq, " rdata"}, rdata, expR);
    @(negedge clk);
    chk({rq, " R9 single pulse"}, done, 0);
    chk({rq, " cycle over"}, cycValid, 0);
  endtask

  task automatic testReset();
    chk("R1 reqReady", reqReady, 1);
    chk("R1 cycValid", cycValid, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {rdLo_n, rdHi_n, wrLo_n, wrHi_n}, 4'hF);
  endtask

  task automatic testIdleStrobes();
    rdCmd_n = 1'b0; wrCmd_n = 1'b0;
    #1;
    chk("R7 idle strobes", {rdLo_n, rdHi_n, wrLo_n, wrHi_n}, 4'hF);
    @(negedge clk);
    chk("R7 idle strobes later", {rdLo_n, rdHi_n, wrLo_n, wrHi_n}, 4'hF);
    rdCmd_n = 1'b1; wrCmd_n = 1'b1;
  endtask

  // held request during a split write; done and next acceptance coincide
  task automatic testBusyOverlap();
    reqValid = 1'b1; reqWrite = 1'b1; reqWord = 1'b1;
    reqAddr = 20'h00123; reqWdata = 16'hBEEF;
    @(negedge clk);
    reqWord = 1'b0; reqAddr = 20'h00200; reqWdata = 16'h0077;
    chk("R8 not ready while busy", reqReady, 0);
    serveCycle("R8 overlap first", 20'h00123, 1'b0, 16'hEF00, 1'b1, 1);
    serveCycle("R8 overlap second", 20'h00124, 1'b1, 16'h00BE, 1'b1, 0);
    chk("R9 overlap done", done, 1);
    chk("R9 overlap ready", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    serveCycle("R2 held request", 20'h00200, 1'b1, 16'h0077, 1'b1, 0);
    chk("R9 held request done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIdleStrobes();
    xfer("R2 even byte write", 1'b1, 1'b0, 20'h01230, 16'h55C3, 0);
    xfer("R2 even byte read",  1'b0, 1'b0, 20'h04A6C, 16'h0000, 1);
    xfer("R3 odd byte write",  1'b1, 1'b0, 20'h01231, 16'h9A3C, 2);
    xfer("R3 odd byte read",   1'b0, 1'b0, 20'h7F0E5, 16'h0000, 0);
    xfer("R4 even word write", 1'b1, 1'b1, 20'h20002, 16'h1234, 3);
    xfer("R4 even word read",  1'b0, 1'b1, 20'hABCDE, 16'h0000, 0);
    xfer("R5 odd word write",  1'b1, 1'b1, 20'h00FFF, 16'hA1B2, 1);
    xfer("R5 odd word read",   1'b0, 1'b1, 20'h3C2D7, 16'h0000, 2);
    xfer("R10 wrap read",      1'b0, 1'b1, 20'hFFFFF, 16'h0000, 0);
    xfer("R10 wrap write",     1'b1, 1'b1, 20'hFFFFF, 16'hC0DE, 0);
    testBusyOverlap();
    testIdleStrobes();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule